// File: doc/BRIEF.md
# Periodic Tick Timer

This block produces the periodic operating-system tick. A down-counter is preset from a programmable divider and then started. Each time it runs out it refills itself from the divider and raises a pending status flag. That flag passes through a mask to a single interrupt line and stays set until software clears it by writing a one to an acknowledge register. The counter's current value can be read at any moment, so software can measure time within a tick as divider minus count.

Software reaches the block through a one-cycle write strobe and a read strobe that share an address bus. The read data is combinational and valid in the cycle the read strobe is high. A frequency-select bit picks the rate at which the counter steps. It either steps on every clock (100 MHz with the nominal clock, so a divider of 1,000,000 gives 100 Hz) or once every `PRESCALE` clocks.

Top module: `tick_timer`

## Requirements
- R1: After reset, the divider, count, control readback, raw status and mask all read 0, and `irq` is low.
- R2: Register addresses are: 0 divider (read/write), 1 control, 2 live count (read-only), 3 raw status (bit 0), 4 mask (bit 0, read/write), 5 masked status, 6 acknowledge (write-only, reads 0). A written divider or mask value reads back unchanged.
- R3: Writing control with operation field bits[1:0]=1 (load) copies the divider into the counter and halts counting. Control reads back the running flag in bit 0 and the frequency select in bit 4.
- R4: Operation 2 (run) starts counting, and the first step comes one clock after the write. After n steps from a count of D, the count reads D − (n mod D). The step that leaves a count of 1 instead refills the counter from the divider and sets raw status bit 0.
- R5: With control bit 4 = 1, a step happens only on every `PRESCALE`-th clock while running. The prescale phase restarts on load.
- R6: Operation 3 (stop) takes effect after the step in its own cycle. From then on the count holds its value, and pending status is kept.
- R7: Writing acknowledge with bit 0 = 1 clears raw status bit 0. Writing it with bit 0 = 0 has no effect.
- R8: When an acknowledge and an expiry fall in the same clock, raw status stays set.
- R9: Masked status equals raw status AND mask, and `irq` is the OR of the masked status bits.
- R10: A divider written while the timer runs does not change the current count. It is used from the next refill onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, 0 when `rd_en` is low |
| irq | output | 1 | Tick interrupt request |

## Verification
Two events can land on the same clock edge: an acknowledge write, and the expiry that would set the status bit again. The bench times an acknowledge exactly onto the edge where the counter refills. It then checks that raw status still reads 1 and that the count has restarted from the divider. A second acknowledge, placed away from any expiry, must clear the bit. An acknowledge written with bit 0 = 0 must leave the bit set.

// File: rtl/tt_pkg.sv
package tt_pkg;

  localparam int ADDR_W   = 3;
  localparam int FREQ_BIT = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIV    = 3'd0,
    RA_CTRL   = 3'd1,
    RA_COUNT  = 3'd2,
    RA_RAW    = 3'd3,
    RA_MASK   = 3'd4,
    RA_MASKED = 3'd5,
    RA_ACK    = 3'd6,
    RA_SPARE  = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_RUN  = 2'd2,
    OP_STOP = 2'd3
  } tmr_op_e;

endpackage

// File: rtl/tt_regs.sv
module tt_regs
  import tt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NSRC    = 1,
  parameter int DIV_RST = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] div_q,
  output logic [NSRC-1:0]   mask_q,
  output logic              freq_q,
  output logic              load_op,
  output logic              run_op,
  output logic              stop_op,
  output logic [NSRC-1:0]   ack_vec
);

  logic    ctrl_wr;
  tmr_op_e wr_op;

  assign ctrl_wr = wr_en && (reg_addr_e'(addr) == RA_CTRL);
  assign wr_op   = tmr_op_e'(wdata[1:0]);

  // Decoded one-cycle command pulses toward the counter.
  assign load_op = ctrl_wr && (wr_op == OP_LOAD);
  assign run_op  = ctrl_wr && (wr_op == OP_RUN);
  assign stop_op = ctrl_wr && (wr_op == OP_STOP);
  assign ack_vec = (wr_en && (reg_addr_e'(addr) == RA_ACK)) ? wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DATA_W'(DIV_RST);
      mask_q <= '0;
      freq_q <= 1'b0;
    end else if (wr_en) begin
      case (reg_addr_e'(addr))
        RA_DIV:  div_q  <= wdata;
        RA_MASK: mask_q <= wdata[NSRC-1:0];
        RA_CTRL: freq_q <= wdata[FREQ_BIT];
        default: ;
      endcase
    end
  end

  p_single_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({load_op, run_op, stop_op}) <= 1);

endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int CNT_W    = 32,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] div_q,
  input  logic             freq_q,
  input  logic             load_op,
  input  logic             run_op,
  input  logic             stop_op,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             expire
);

  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic            slow_tick;
  logic            step;
  logic [PS_W-1:0] psc_q;

  function automatic logic is_last(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] c,
    input logic [CNT_W-1:0] d,
    input logic             ld,
    input logic             st
  );
    if (ld)                  return d;
    else if (st && is_last(c)) return d;
    else if (st)             return c - CNT_W'(1);
    else                     return c;
  endfunction

  generate
    if (PRESCALE > 1) begin : g_presc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             psc_q <= '0;
        else if (load_op)                       psc_q <= '0;
        else if (run_q && slow_tick)            psc_q <= '0;
        else if (run_q)                         psc_q <= psc_q + PS_W'(1);
      end
      assign slow_tick = (psc_q == PS_W'(PRESCALE - 1));
    end else begin : g_nopresc
      assign psc_q     = '0;
      assign slow_tick = 1'b1;
    end
  endgenerate

  assign step   = run_q && (freq_q ? slow_tick : 1'b1);
  assign expire = step && is_last(cnt_q) && !load_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= next_count(cnt_q, div_q, load_op, step);
      if (load_op || stop_op) run_q <= 1'b0;
      else if (run_op)        run_q <= 1'b1;
    end
  end

  p_load_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_op |=> (cnt_q == $past(div_q)) && !run_q);

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt_q == $past(div_q));

  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !expire && !load_op) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load_op) |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/tt_irq.sv
module tt_irq #(
  parameter int NSRC = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] ack_vec,
  input  logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] raw_q,
  output logic [NSRC-1:0] masked,
  output logic            irq
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          raw_q[i] <= 1'b0;
      else if (set_vec[i]) raw_q[i] <= 1'b1;
      else if (ack_vec[i]) raw_q[i] <= 1'b0;
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> raw_q[i]);

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vec[i] && !set_vec[i]) |=> !raw_q[i]);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_vec[i] && raw_q[i]) |=> raw_q[i]);
  end

  assign masked = raw_q & mask_q;
  assign irq    = |masked;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PRESCALE = 4,
  parameter int DIV_RST  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam int NSRC = 1;

  logic [DATA_W-1:0] div_q;
  logic [DATA_W-1:0] cnt_q;
  logic [NSRC-1:0]   mask_q, ack_vec, raw_q, masked;
  logic              freq_q, load_op, run_op, stop_op, run_q, expire;

  tt_regs #(.DATA_W(DATA_W), .NSRC(NSRC), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .div_q(div_q), .mask_q(mask_q), .freq_q(freq_q),
    .load_op(load_op), .run_op(run_op), .stop_op(stop_op), .ack_vec(ack_vec)
  );

  tt_counter #(.CNT_W(DATA_W), .PRESCALE(PRESCALE)) u_cnt (
    .clk(clk), .rst_n(rst_n), .div_q(div_q), .freq_q(freq_q),
    .load_op(load_op), .run_op(run_op), .stop_op(stop_op),
    .cnt_q(cnt_q), .run_q(run_q), .expire(expire)
  );

  tt_irq #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(expire), .ack_vec(ack_vec),
    .mask_q(mask_q), .raw_q(raw_q), .masked(masked), .irq(irq)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (reg_addr_e'(addr))
        RA_DIV:    rdata = div_q;
        RA_CTRL:   begin rdata[0] = run_q; rdata[FREQ_BIT] = freq_q; end
        RA_COUNT:  rdata = cnt_q;
        RA_RAW:    rdata = DATA_W'(raw_q);
        RA_MASK:   rdata = DATA_W'(mask_q);
        RA_MASKED: rdata = DATA_W'(masked);
        default:   rdata = '0;
      endcase
    end
  end

  p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|mask_q) && (|raw_q));

endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  localparam int DW = 32;
  localparam int PS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int errors = 0, checks = 0, ops = 0;

  typedef struct { logic [DW-1:0] e; string tag; } exp_t;
  exp_t sb[$];

  tick_timer #(.DATA_W(DW), .PRESCALE(PS), .DIV_RST(0)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); ops++;
    wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
  endtask

  task automatic rd(input logic [2:0] a, input logic [DW-1:0] e, input string tag);
    exp_t it;
    @(negedge clk); ops++;
    wr_en = 1'b0; rd_en = 1'b1; addr = a;
    it.e = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk); ops++;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic irq_chk(input logic e, input string tag);
    idle();
    #3;
    check(irq == e, tag, DW'(irq), DW'(e));
  endtask

  task automatic until_op(input int target);
    while (ops < target - 1) idle();
  endtask

  // Count after n full-rate steps from a preset d.
  function automatic logic [DW-1:0] cnt_after(input int d, input int n);
    return DW'(d - (n % d));
  endfunction

  // Monitor: pops the scoreboard in every read cycle, mid low phase.
  always @(negedge clk) begin
    #3;
    if (rd_en) begin
      if (sb.size() == 0) begin
        check(1'b0, "scoreboard underflow", rdata, '0);
      end else begin
        exp_t it;
        it = sb.pop_front();
        check(rdata == it.e, it.tag, rdata, it.e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired: actual=%0d expected=%0d", ops, 0);
    summary();
    $finish;
  end

  initial begin
    int r, r2, q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, 0, "R1 divider");
    rd(3'd2, 0, "R1 count");
    rd(3'd3, 0, "R1 raw");
    rd(3'd4, 0, "R1 mask");
    irq_chk(1'b0, "R1 irq");
    rd(3'd1, 0, "R1 ctrl");

    // R2 readback, R3 load
    wr(3'd0, 10);
    rd(3'd0, 10, "R2 divider readback");
    wr(3'd1, 32'h1);
    rd(3'd2, 10, "R3 load copies divider");
    rd(3'd1, 0, "R3 halted after load");
    wr(3'd1, 32'h2);
    r = ops;
    // Op i sees n = i-1-r steps (R4)
    rd(3'd2, cnt_after(10, 0), "R4 count before first step");
    rd(3'd2, cnt_after(10, 1), "R4 first decrement");
    until_op(r + 8);
    rd(3'd3, 0, "R4 no expiry yet");
    rd(3'd2, cnt_after(10, 8), "R4 count near end");
    // expiry on edge of op r+10; ack lands on it (R8)
    wr(3'd6, 32'h1);
    rd(3'd3, 1, "R8 expiry wins over ack");
    rd(3'd2, cnt_after(10, 11), "R4 refill from divider");
    wr(3'd6, 32'h0);
    rd(3'd3, 1, "R7 ack with bit0=0 ignored");
    wr(3'd6, 32'h1);
    rd(3'd3, 0, "R7 ack clears raw");
    // R10 divider rewrite mid-period
    wr(3'd0, 4);
    rd(3'd2, cnt_after(10, 17), "R10 current period unchanged");
    rd(3'd5, 0, "R9 masked with raw clear");
    until_op(r + 21);
    rd(3'd2, 4, "R10 new divider after refill");
    rd(3'd2, 3, "R10 counting from new divider");
    irq_chk(1'b0, "R9 masked-off irq low");
    rd(3'd5, 0, "R9 masked status zero with mask 0");
    wr(3'd4, 32'h1);
    rd(3'd4, 1, "R2 mask readback");
    irq_chk(1'b1, "R9 irq with mask set");
    rd(3'd5, 1, "R9 masked status");
    // R6 stop: after refill at op r+24 edge, op r+29 edge leaves 4-(9%4)=3
    until_op(r + 29);
    wr(3'd1, 32'h3);
    rd(3'd2, 3, "R6 frozen count");
    idle(); idle(); idle();
    rd(3'd2, 3, "R6 count still frozen");
    rd(3'd3, 1, "R6 pending kept after stop");
    wr(3'd6, 32'h1);
    irq_chk(1'b0, "R7 irq drops after ack");

    // R5 prescaled stepping
    wr(3'd0, 3);
    wr(3'd1, 32'h11);
    wr(3'd1, 32'h12);
    r2 = ops;
    rd(3'd1, 32'h11, "R3 ctrl shows running and freq");
    until_op(r2 + 4);
    rd(3'd2, 3, "R5 no step before prescale period");
    rd(3'd2, 2, "R5 first slow step");
    until_op(r2 + 9);
    rd(3'd2, 1, "R5 second slow step");
    until_op(r2 + 13);
    rd(3'd2, 3, "R5 slow refill");
    rd(3'd3, 1, "R5 slow expiry sets raw");
    // R3 load while running halts
    wr(3'd1, 32'h11);
    q = ops;
    rd(3'd1, 32'h10, "R3 load stops running");
    rd(3'd2, 3, "R3 load preset count");
    if (q < 0) $display("unreachable");

    idle(); idle();
    check(sb.size() == 0, "scoreboard drained", DW'(sb.size()), 0);
    summary();
    $finish;
  end

endmodule